// File: doc/BRIEF.md
# Width-Adaptive Byte FIFO for a Card Data Path

This block is the byte queue between a card transfer sequencer and the CPU-visible data register of a storage-card host. It stores up to 64 bytes in a circular buffer. The sequencer adds or removes one byte per strobe. The CPU moves one, two or four bytes per access, always least significant byte first. In the receive direction the sequencer fills the queue and the CPU drains it. In the transmit direction the CPU fills it and the sequencer drains it.

A status word reports the occupancy in every mode. Its flag bits change meaning with the transfer direction. Interrupt pulses mark the moment a threshold is crossed, not the time spent beyond it, so a CPU or DMA handler is woken once per crossing. A flush input empties the queue. A push that finds no room is dropped and sets a sticky overrun bit.

Top module: `xfer_byte_fifo`

## Requirements
- R1: After reset the queue is empty, the status word in idle mode reads 0, no interrupt pulse is active, `cpu_rdata` is 0 and `cpu_underrun` is 0.
- R2: Bytes leave in the order they entered, and the buffer wraps around its 64 entries. A CPU read of size 2 (word) returns the four oldest bytes with the oldest in bits 7:0. Size 1 (halfword) returns two bytes and size 0 (byte) returns one, with the unused upper bits zero. Size 3 acts as a word.
- R3: A CPU read that needs more bytes than are held removes nothing. It pulses `cpu_underrun` and returns 0.
- R4: A CPU write pushes 1, 2 or 4 bytes, least significant byte first. `seq_pop_data` always shows the oldest byte, and a sequencer pop removes it. A pop on an empty queue does nothing.
- R5: Occupancy never exceeds 64. A push that finds no room is dropped. When a write is only partly taken, its leading bytes that fit are stored. Any dropped byte sets status bit 14, which stays set until flush.
- R6: In receive mode (`xfer_mode`=2) the status word is laid out as follows. Bits 6:0 hold the occupancy. Bit 7 is set when occupancy >= 32 and bit 8 when occupancy = 64. Bit 9 follows `cnt_zero`. Bits 11:10 read 1, and bit 12 is set when the queue is non-empty.
- R7: In transmit mode (`xfer_mode`=3) the status word is laid out as follows. Bits 6:0 hold the occupancy. Bit 10 is set when the queue is empty, bit 11 when occupancy <= 32, and bit 13 when occupancy < 64.
- R8: In other modes the status word holds only the occupancy in bits 6:0 and the overrun bit 14. The queue still operates in these modes.
- R9: In receive mode, `irq_pulse[0]` pulses for one cycle when occupancy goes from below 32 to 32 or more. `irq_pulse[1]` pulses when occupancy goes from below 64 to 64.
- R10: In receive mode, `irq_pulse[2]` pulses for one cycle when `cnt_zero` rises.
- R11: In transmit mode, `irq_pulse[3]` pulses when a non-empty queue reaches 0. `irq_pulse[4]` pulses when occupancy goes from above 32 to 32 or fewer.
- R12: A pulse appears only while its bit in `irq_mask` is set, using the same bit positions as `irq_pulse`.
- R13: Flush empties the queue and clears the overrun bit. It raises no pulse, and every other request in that cycle is ignored.
- R14: In a cycle with a CPU access, sequencer push and pop strobes are ignored. When both sequencer strobes arrive together on a full queue, the pop is taken and the push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the queue |
| xfer_mode | input | 2 | 2 receive, 3 transmit, else idle |
| cnt_zero | input | 1 | Transfer byte counter is zero |
| irq_mask | input | 5 | Enable per interrupt pulse |
| seq_push | input | 1 | Sequencer adds a byte |
| seq_push_data | input | 8 | Byte to add |
| seq_pop | input | 1 | Sequencer removes the oldest byte |
| seq_pop_data | output | 8 | Oldest byte |
| cpu_valid | input | 1 | CPU access this cycle |
| cpu_write | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, registered |
| cpu_underrun | output | 1 | Pulse: read refused |
| fifo_status | output | 16 | Occupancy and direction flags |
| irq_pulse | output | 5 | 0 rx half, 1 rx full, 2 rx last, 3 tx empty, 4 tx half |

## Verification
The receive path is exercised by filling the queue byte by byte to full. It is then drained with a rotating mix of word, halfword and byte reads while fresh bytes keep arriving. This walks both indices around the wrap point and separates byte-order mistakes from off-by-one errors in the index. The transmit path is filled with mixed-size writes until a write is only partly taken. It is then drained by single pops, which checks that the half and empty pulses fire exactly on the crossing cycle and at no other step. Further passes probe underrun at each size, flush combined with other strobes, a cleared mask, the idle mode and CPU accesses that collide with sequencer strobes.

// File: rtl/xbf_pkg.sv
// Package: shared encodings for the width-adaptive byte FIFO.
package xbf_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_t;

    localparam logic [1:0] MODE_RX = 2'd2;
    localparam logic [1:0] MODE_TX = 2'd3;

    localparam int IRQ_RX_HALF  = 0;
    localparam int IRQ_RX_FULL  = 1;
    localparam int IRQ_RX_LAST  = 2;
    localparam int IRQ_TX_EMPTY = 3;
    localparam int IRQ_TX_HALF  = 4;
    localparam int IRQ_W        = 5;
endpackage

// File: rtl/xbf_store.sv
// Module: xbf_store
// Circular byte memory. Each cycle it writes up to four consecutive
// bytes starting at wr_base, and it presents four consecutive bytes
// starting at rd_base. Assumes DEPTH is a power of two so that the
// indices wrap naturally. The memory is not reset.
module xbf_store #(
    parameter int DEPTH = 64,
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic [2:0]               wr_cnt,
    input  logic [$clog2(DEPTH)-1:0] wr_base,
    input  logic [8*LANES-1:0]       wr_bytes,
    input  logic [$clog2(DEPTH)-1:0] rd_base,
    output logic [8*LANES-1:0]       rd_bytes
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    // Write the leading wr_cnt lanes at consecutive wrapped indices.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(wr_cnt)) mem[wr_base + AW'(k)] <= wr_bytes[8*k +: 8];
        end
    end

    // Present the lanes from the read index onward.
    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rd_bytes[8*g +: 8] = mem[rd_base + AW'(g)];
    end
endmodule

// File: rtl/xbf_status.sv
// Module: xbf_status
// Builds the status word from occupancy, direction, the counter-zero
// input and the overrun flag. Purely combinational. Assumes
// DEPTH <= 64 so that the occupancy fits in bits 6:0.
module xbf_status #(
    parameter int DEPTH = 64
) (
    input  logic [1:0]               mode,
    input  logic [$clog2(DEPTH):0]   occ,
    input  logic                     cnt_zero,
    input  logic                     ovf,
    output logic [15:0]              status
);
    import xbf_pkg::*;
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    // Assemble the direction-dependent flag set.
    always_comb begin
        status           = '0;
        status[CW-1:0]   = occ;
        status[14]       = ovf;
        if (mode == MODE_RX) begin
            status[7]     = occ >= CW'(HALF);
            status[8]     = occ == CW'(DEPTH);
            status[9]     = cnt_zero;
            status[11:10] = 2'b11;
            status[12]    = occ != '0;
        end else if (mode == MODE_TX) begin
            status[10]    = occ == '0;
            status[11]    = occ <= CW'(HALF);
            status[13]    = occ < CW'(DEPTH);
        end
    end
endmodule

// File: rtl/xbf_irq.sv
// Module: xbf_irq
// Turns occupancy changes and the counter-zero edge into one-cycle
// interrupt pulses. Compares the current occupancy with the next-cycle
// value, so each pulse is registered alongside the new occupancy.
// Flush produces no pulse.
module xbf_irq #(
    parameter int DEPTH = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [1:0]             mode,
    input  logic [4:0]             mask,
    input  logic                   cnt_zero,
    input  logic [$clog2(DEPTH):0] occ_now,
    input  logic [$clog2(DEPTH):0] occ_next,
    output logic [4:0]             irq_pulse
);
    import xbf_pkg::*;
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic             cz_q;
    logic [IRQ_W-1:0] irq_d;
    logic [IRQ_W-1:0] irq_q;

    // Detect level crossings for the current direction.
    always_comb begin
        irq_d = '0;
        if (mode == MODE_RX) begin
            irq_d[IRQ_RX_HALF] = (occ_now < CW'(HALF))  && (occ_next >= CW'(HALF));
            irq_d[IRQ_RX_FULL] = (occ_now < CW'(DEPTH)) && (occ_next == CW'(DEPTH));
            irq_d[IRQ_RX_LAST] = cnt_zero && !cz_q;
        end else if (mode == MODE_TX) begin
            irq_d[IRQ_TX_EMPTY] = (occ_now != '0)       && (occ_next == '0);
            irq_d[IRQ_TX_HALF]  = (occ_now > CW'(HALF)) && (occ_next <= CW'(HALF));
        end
        if (flush) irq_d = '0;
        irq_d = irq_d & mask;
    end

    // Register the pulses and the previous counter-zero level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            cz_q  <= 1'b1;
        end else begin
            irq_q <= irq_d;
            cz_q  <= cnt_zero;
        end
    end

    assign irq_pulse = irq_q;

    assert_rx_full_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[IRQ_RX_FULL] |-> occ_now == CW'(DEPTH));
    assert_rx_half_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[IRQ_RX_HALF] |-> occ_now >= CW'(HALF));
    assert_tx_empty_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[IRQ_TX_EMPTY] |-> occ_now == '0);
    assert_tx_half_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[IRQ_TX_HALF] |-> occ_now <= CW'(HALF));
endmodule

// File: rtl/xfer_byte_fifo.sv
// Module: xfer_byte_fifo
// 64-byte circular queue between a transfer sequencer (one byte per
// strobe) and a CPU data port of 1, 2 or 4 bytes, little-endian.
// Assumes DEPTH is a power of two no larger than 64. A CPU access takes
// precedence over the sequencer strobes in the same cycle, and flush
// takes precedence over everything.
module xfer_byte_fifo #(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [1:0]  xfer_mode,
    input  logic        cnt_zero,
    input  logic [4:0]  irq_mask,
    input  logic        seq_push,
    input  logic [7:0]  seq_push_data,
    input  logic        seq_pop,
    output logic [7:0]  seq_pop_data,
    input  logic        cpu_valid,
    input  logic        cpu_write,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_underrun,
    output logic [15:0] fifo_status,
    output logic [4:0]  irq_pulse
);
    import xbf_pkg::*;
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [AW-1:0] rd_idx_q;
    logic [CW-1:0] occ_q, occ_d, free_c;
    logic          ovf_q;
    logic [31:0]   rdata_q;
    logic          underrun_q;

    logic [2:0]    acc_n, pop_n, push_n, req_n;
    logic          cpu_rd, cpu_wr, rd_ok, rd_bad, seq_go, push_drop;
    logic [31:0]   wr_bytes, rd_bytes, rd_masked;
    logic [AW-1:0] wr_base;

    // Decode the access size and decide how many bytes move this cycle.
    always_comb begin
        case (acc_size_t'(cpu_size))
            SZ_BYTE: acc_n = 3'd1;
            SZ_HALF: acc_n = 3'd2;
            default: acc_n = 3'd4;
        endcase
        cpu_rd    = cpu_valid && !cpu_write;
        cpu_wr    = cpu_valid && cpu_write;
        seq_go    = !cpu_valid;
        rd_ok     = cpu_rd && (occ_q >= CW'(acc_n));
        rd_bad    = cpu_rd && !rd_ok;
        pop_n     = rd_ok ? acc_n : ((seq_go && seq_pop && occ_q != '0) ? 3'd1 : 3'd0);
        free_c    = CW'(DEPTH) - occ_q;
        req_n     = cpu_wr ? acc_n : ((seq_go && seq_push) ? 3'd1 : 3'd0);
        push_drop = CW'(req_n) > free_c;
        push_n    = push_drop ? free_c[2:0] : req_n;
        wr_bytes  = cpu_wr ? cpu_wdata : {24'b0, seq_push_data};
        wr_base   = rd_idx_q + occ_q[AW-1:0];
        occ_d     = flush ? '0 : (occ_q - CW'(pop_n) + CW'(push_n));
    end

    // Trim the read lanes to the access size.
    always_comb begin
        case (acc_size_t'(cpu_size))
            SZ_BYTE: rd_masked = {24'b0, rd_bytes[7:0]};
            SZ_HALF: rd_masked = {16'b0, rd_bytes[15:0]};
            default: rd_masked = rd_bytes;
        endcase
    end

    // Advance the read index and occupancy, and capture the read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx_q   <= '0;
            occ_q      <= '0;
            ovf_q      <= 1'b0;
            rdata_q    <= '0;
            underrun_q <= 1'b0;
        end else if (flush) begin
            rd_idx_q   <= '0;
            occ_q      <= '0;
            ovf_q      <= 1'b0;
            underrun_q <= 1'b0;
        end else begin
            rd_idx_q   <= rd_idx_q + AW'(pop_n);
            occ_q      <= occ_d;
            ovf_q      <= ovf_q || push_drop;
            underrun_q <= rd_bad;
            if (rd_ok)  rdata_q <= rd_masked;
            if (rd_bad) rdata_q <= '0;
        end
    end

    xbf_store #(.DEPTH(DEPTH), .LANES(4)) u_store (
        .clk      (clk),
        .wr_cnt   (flush ? 3'd0 : push_n),
        .wr_base  (wr_base),
        .wr_bytes (wr_bytes),
        .rd_base  (rd_idx_q),
        .rd_bytes (rd_bytes)
    );

    xbf_status #(.DEPTH(DEPTH)) u_status (
        .mode     (xfer_mode),
        .occ      (occ_q),
        .cnt_zero (cnt_zero),
        .ovf      (ovf_q),
        .status   (fifo_status)
    );

    xbf_irq #(.DEPTH(DEPTH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .mode      (xfer_mode),
        .mask      (irq_mask),
        .cnt_zero  (cnt_zero),
        .occ_now   (occ_q),
        .occ_next  (occ_d),
        .irq_pulse (irq_pulse)
    );

    assign seq_pop_data = rd_bytes[7:0];
    assign cpu_rdata    = rdata_q;
    assign cpu_underrun = underrun_q;

    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CW'(DEPTH));
    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !flush) |=> ovf_q);
    assert_underrun_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bad && !flush) |=> (underrun_q && occ_q == $past(occ_q)));
    assert_flush_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ_q == '0 && !ovf_q && irq_pulse == '0));
    assert_cpu_write_no_pop_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_write && !flush) |=> occ_q >= $past(occ_q));
endmodule

// File: tb/xfer_byte_fifo_bench.sv
module xfer_byte_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  xfer_mode = 2'd0;
    logic        cnt_zero = 1'b0;
    logic [4:0]  irq_mask = 5'h1f;
    logic        seq_push = 1'b0;
    logic [7:0]  seq_push_data = 8'h0;
    logic        seq_pop = 1'b0;
    logic [7:0]  seq_pop_data;
    logic        cpu_valid = 1'b0;
    logic        cpu_write = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_wdata = 32'h0;
    logic [31:0] cpu_rdata;
    logic        cpu_underrun;
    logic [15:0] fifo_status;
    logic [4:0]  irq_pulse;

    always #2 clk = ~clk;

    xfer_byte_fifo u_xfer_byte_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .xfer_mode(xfer_mode),
        .cnt_zero(cnt_zero), .irq_mask(irq_mask), .seq_push(seq_push),
        .seq_push_data(seq_push_data), .seq_pop(seq_pop), .seq_pop_data(seq_pop_data),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_underrun(cpu_underrun),
        .fifo_status(fifo_status), .irq_pulse(irq_pulse)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mq[$];
    bit ovf_m = 0;
    bit cz_prev = 1;
    int tx_seed = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_st(int n, logic [1:0] m, bit cz, bit ov);
        logic [15:0] s;
        s = '0;
        s[6:0] = 7'(n);
        s[14]  = ov;
        if (m == 2'd2) begin
            s[7] = n >= 32; s[8] = n == 64; s[9] = cz; s[11:10] = 2'b11; s[12] = n != 0;
        end else if (m == 2'd3) begin
            s[10] = n == 0; s[11] = n <= 32; s[13] = n < 64;
        end
        return s;
    endfunction

    // One clocked operation with model update and checks.
    task automatic op(bit cv, bit cw, logic [1:0] csz, logic [31:0] cwd,
                      bit sp, logic [7:0] spd, bit spo, bit fl, string tag);
        int pre, post, n;
        logic [31:0] exp_rd;
        logic [4:0]  exp_irq;
        bit rise;
        pre = mq.size();
        if (!cv && !fl && spo && pre > 0) chk(tag, "pop byte", {24'b0, seq_pop_data}, {24'b0, mq[0]});
        cpu_valid = cv; cpu_write = cw; cpu_size = csz; cpu_wdata = cwd;
        seq_push = sp; seq_push_data = spd; seq_pop = spo; flush = fl;
        @(negedge clk);
        cpu_valid = 0; seq_push = 0; seq_pop = 0; flush = 0;
        rise = cnt_zero && !cz_prev;
        cz_prev = cnt_zero;
        n = (csz == 2'd0) ? 1 : (csz == 2'd1) ? 2 : 4;
        if (fl) begin
            mq.delete(); ovf_m = 0;
        end else if (cv && !cw) begin
            if (pre >= n) begin
                exp_rd = 0;
                for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = mq.pop_front();
                chk(tag, "read data", cpu_rdata, exp_rd);
                chk(tag, "no underrun", {31'b0, cpu_underrun}, 32'd0);
            end else begin
                chk("R3", "underrun flag", {31'b0, cpu_underrun}, 32'd1);
                chk("R3", "underrun data", cpu_rdata, 32'd0);
            end
        end else if (cv && cw) begin
            for (int i = 0; i < n; i++) begin
                if (pre + i < 64) mq.push_back(cwd[8*i +: 8]);
                else ovf_m = 1;
            end
        end else begin
            if (spo && pre > 0) void'(mq.pop_front());
            if (sp) begin
                if (pre < 64) mq.push_back(spd);
                else ovf_m = 1;
            end
        end
        post = mq.size();
        exp_irq = 0;
        if (!fl) begin
            if (xfer_mode == 2'd2) begin
                exp_irq[0] = pre < 32 && post >= 32;
                exp_irq[1] = pre < 64 && post == 64;
                exp_irq[2] = rise;
            end else if (xfer_mode == 2'd3) begin
                exp_irq[3] = pre != 0 && post == 0;
                exp_irq[4] = pre > 32 && post <= 32;
            end
        end
        exp_irq = exp_irq & irq_mask;
        chk(tag, "irq", {27'b0, irq_pulse}, {27'b0, exp_irq});
        chk(tag, "status", {16'b0, fifo_status}, {16'b0, exp_st(post, xfer_mode, cnt_zero, ovf_m)});
    endtask

    function automatic logic [31:0] tx_word();
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'((tx_seed + i) * 13 + 1);
        return w;
    endfunction

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "status", {16'b0, fifo_status}, 32'd0);
        chk("R1", "irq", {27'b0, irq_pulse}, 32'd0);
        chk("R1", "rdata", cpu_rdata, 32'd0);
        chk("R1", "underrun", {31'b0, cpu_underrun}, 32'd0);

        // R2 R6 R9: receive fill to full
        xfer_mode = 2'd2;
        for (int i = 0; i < 64; i++) op(0, 0, 0, 0, 1, 8'(i * 37 + 5), 0, 0, "R9");
        // R5 overrun on full
        op(0, 0, 0, 0, 1, 8'hAA, 0, 0, "R5");
        // R14 push and pop together on full: pop wins, push dropped
        op(0, 0, 0, 0, 1, 8'hBB, 1, 0, "R14");
        // R10 counter-zero rise
        cnt_zero = 1'b1;
        op(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        op(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        cnt_zero = 1'b0;
        op(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // R2 mixed-size reads with refills, walking across the wrap
        for (int k = 0; k < 60; k++) begin
            op(1, 0, 2'((k % 4 == 3) ? 3 : k % 3), 0, 0, 0, 0, 0, "R2");
            op(0, 0, 0, 0, 1, 8'(k * 11 + 2), 0, 0, "R2");
        end
        // R3 underrun at each size
        while (mq.size() > 1) op(1, 0, 2'd0, 0, 0, 0, 0, 0, "R2");
        op(1, 0, 2'd2, 0, 0, 0, 0, 0, "R3");
        op(1, 0, 2'd1, 0, 0, 0, 0, 0, "R3");
        op(1, 0, 2'd0, 0, 0, 0, 0, 0, "R2");
        op(1, 0, 2'd0, 0, 0, 0, 0, 0, "R3");
        // R14 CPU read with sequencer push in same cycle: push ignored
        op(0, 0, 0, 0, 1, 8'h11, 0, 0, "R14");
        op(0, 0, 0, 0, 1, 8'h22, 0, 0, "R14");
        op(1, 0, 2'd0, 0, 1, 8'h33, 0, 0, "R14");
        op(1, 0, 2'd0, 0, 1, 8'h44, 1, 0, "R14");
        op(1, 0, 2'd0, 0, 0, 0, 0, 0, "R14");
        // R13 flush with a push in the same cycle
        for (int i = 0; i < 40; i++) op(0, 0, 0, 0, 1, 8'(i), 0, 0, "R6");
        op(0, 0, 0, 0, 1, 8'h55, 0, 1, "R13");

        // R4 R7 R11 R5: transmit fill with mixed writes until partial
        xfer_mode = 2'd3;
        for (int k = 0; k < 30; k++) begin
            op(1, 1, 2'(k % 3), tx_word(), 0, 0, 0, 0, "R5");
            tx_seed += 4;
        end
        op(0, 0, 0, 0, 0, 0, 1, 0, "R4");
        while (mq.size() > 0) op(0, 0, 0, 0, 0, 0, 1, 0, "R11");
        op(0, 0, 0, 0, 0, 0, 1, 0, "R4");
        op(0, 0, 0, 0, 0, 0, 0, 1, "R13");

        // R12 mask cleared: crossings silent
        irq_mask = 5'h0;
        for (int k = 0; k < 10; k++) begin
            op(1, 1, 2'd2, tx_word(), 0, 0, 0, 0, "R12");
            tx_seed += 4;
        end
        while (mq.size() > 0) op(0, 0, 0, 0, 0, 0, 1, 0, "R12");
        irq_mask = 5'h1f;

        // R8 idle mode
        xfer_mode = 2'd0;
        for (int i = 0; i < 66; i++) op(0, 0, 0, 0, 1, 8'(i * 3), 0, 0, "R8");
        for (int k = 0; k < 8; k++) op(1, 0, 2'd2, 0, 0, 0, 0, 0, "R8");
        op(0, 0, 0, 0, 0, 0, 0, 1, "R13");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule